// File: doc/BRIEF.md
# Sawtooth Correction Delay Programmer

A timing receiver that steps its pulse-per-second output on its own oscillator grid reports, once a second, how far the coming pulse will miss the true second. This block takes that signed report in picoseconds, turns it into an 8-bit setting for an external programmable delay element, and issues that setting at a moment when no second mark is near. The delayed pulse then comes out with the quantization sawtooth removed.

The report applies to the pulse that follows the one it arrived after. The block therefore holds each report until a load window opens after the PPS edge. A report that is still waiting when the next edge comes is dropped. Before quantizing, the report is multiplied by a gain word in Q1.15, because the element's step is not exactly one nanosecond. It is then rounded to whole steps and shifted by an offset code, so that signed corrections land inside the unsigned range. The result is clamped, and then passed through a 256-entry calibration table that corrects the element's integral nonlinearity. The table starts as the identity map and can be rewritten at any time through a simple write port.

Top module: `scd_delay_prog`

## Requirements
- R1: After reset, `delay_code` is 0 and `load_strobe`, `sat_flag` and `stale_flag` are all 0.
- R2: The step index is `code_offset + q`. Here `q = trunc(b / PS_PER_STEP)` and `b = s + PS_PER_STEP/2` when `s >= 0`, or `s - PS_PER_STEP/2` otherwise. `s = floor(corr_ps * gain_q15 / 2^15)`, with `corr_ps` in two's complement and `gain_q15` unsigned. The default `PS_PER_STEP` is 1000.
- R3: An index below 0 is replaced by 0 and an index above 255 by 255. `sat_flag` is 1 after such a load, and 0 after a load that needed no clamping.
- R4: The loaded code is the calibration table entry at the step index. Entry i resets to i. A high `cal_we` writes `cal_wdata` to entry `cal_addr` at the clock edge.
- R5: `load_strobe` and any change of `delay_code` or `sat_flag` occur only when the number of clock edges since the edge that sampled a PPS rise lies between `GUARD_CYC+1` and `LATE_CYC+1` inclusive.
- R6: A report that arrives before the window opens is held, and is loaded once the window opens.
- R7: A report not loaded by the next PPS rise is discarded, and `delay_code` keeps its value.
- R8: At each PPS rise after the first, `stale_flag` goes to 1 if no load happened since the previous rise. A load clears it.
- R9: Each accepted report produces exactly one single-cycle `load_strobe`, and no strobe occurs without a report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| pps_in | input | 1 | Raw PPS level, already synchronous to `clk` |
| corr_valid | input | 1 | One-cycle marker of a new report |
| corr_ps | input | 16 | Signed correction for the next pulse, in picoseconds |
| gain_q15 | input | 16 | Unsigned Q1.15 gain for the delay step size |
| code_offset | input | 8 | Code that a zero correction maps to |
| cal_we | input | 1 | Calibration table write enable |
| cal_addr | input | 8 | Calibration table write address |
| cal_wdata | input | 8 | Calibration table write data |
| delay_code | output | 8 | Setting for the delay element |
| load_strobe | output | 1 | One-cycle pulse when `delay_code` takes a new value |
| sat_flag | output | 1 | The last loaded code was clamped |
| stale_flag | output | 1 | A whole PPS period passed without a load |

## Verification
The assertions assume the following about the inputs:
- `pps_in` comes in from the clock domain already synchronized.
- Rising edges of `pps_in` are spaced well beyond `LATE_CYC`, so a full window fits in every period.
- `corr_valid` is at most one pulse per period.
- `gain_q15` and `code_offset` do not change while a report is moving through the pipeline.

The stimulus runs 100-cycle periods with one 1-cycle PPS pulse each, and sets gain and offset only at the start of a period. It sends reports either at least eight cycles before the window closes or clearly after it, so no report lands on the closing edge. It rewrites the table only between periods.

// File: rtl/scd_pkg.sv
package scd_pkg;

  // Where the cycle counter stands relative to the last PPS rise.
  typedef enum logic [1:0] {
    PH_GUARD  = 2'd0,  // too soon after the edge
    PH_OPEN   = 2'd1,  // loads permitted
    PH_CLOSED = 2'd2   // too close to the next edge
  } scd_phase_e;

endpackage

// File: rtl/scd_edge_timer.sv
module scd_edge_timer #(
  parameter int GUARD_CYC = 16,
  parameter int LATE_CYC  = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pps_in,
  output logic                  pps_rise,
  output scd_pkg::scd_phase_e   phase
);
  import scd_pkg::*;

  localparam int CNT_MAX = LATE_CYC + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic          pps_q;
  logic [CW-1:0] cnt_q, cnt_d;

  assign pps_rise = pps_in & ~pps_q;

  always_comb begin
    cnt_d = cnt_q;
    if (pps_rise)
      cnt_d = '0;
    else if (cnt_q != CW'(CNT_MAX))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pps_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pps_q <= pps_in;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    if (int'(cnt_q) < GUARD_CYC)
      phase = PH_GUARD;
    else if (int'(cnt_q) <= LATE_CYC)
      phase = PH_OPEN;
    else
      phase = PH_CLOSED;
  end

endmodule

// File: rtl/scd_scaler.sv
module scd_scaler #(
  parameter int CORR_W      = 16,
  parameter int SCALE_W     = 16,
  parameter int FRAC_W      = 15,
  parameter int CODE_W      = 8,
  parameter int PS_PER_STEP = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     in_valid,
  input  logic signed [CORR_W-1:0] corr,
  input  logic [SCALE_W-1:0]       scale,
  input  logic [CODE_W-1:0]        offset,
  output logic                     out_valid,
  output logic [CODE_W-1:0]        out_idx,
  output logic                     out_sat
);
  localparam int PW = CORR_W + SCALE_W + 1;
  localparam logic signed [PW-1:0] STEP_S = PW'(PS_PER_STEP);
  localparam logic signed [PW-1:0] HALF_S = PW'(PS_PER_STEP / 2);
  localparam logic signed [PW-1:0] MAXC_S = PW'((1 << CODE_W) - 1);

  // capture stage
  logic                     a_valid_q;
  logic signed [CORR_W-1:0] a_corr_q;

  // arithmetic
  logic signed [PW-1:0] prod, scaled, biased, steps, total;
  logic [CODE_W-1:0]    idx_d;
  logic                 sat_d;

  // result stage
  logic              b_valid_q;
  logic [CODE_W-1:0] b_idx_q;
  logic              b_sat_q;

  always_comb begin
    prod   = PW'(a_corr_q) * PW'($signed({1'b0, scale}));
    scaled = prod >>> FRAC_W;
    biased = (scaled >= 0) ? (scaled + HALF_S) : (scaled - HALF_S);
    steps  = biased / STEP_S;
    total  = steps + $signed({{(PW-CODE_W){1'b0}}, offset});
    if (total < 0) begin
      idx_d = '0;
      sat_d = 1'b1;
    end else if (total > MAXC_S) begin
      idx_d = '1;
      sat_d = 1'b1;
    end else begin
      idx_d = total[CODE_W-1:0];
      sat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid_q <= 1'b0;
      a_corr_q  <= '0;
    end else begin
      a_valid_q <= in_valid;
      if (in_valid)
        a_corr_q <= corr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_valid_q <= 1'b0;
      b_idx_q   <= '0;
      b_sat_q   <= 1'b0;
    end else begin
      b_valid_q <= a_valid_q & ~flush;
      if (a_valid_q) begin
        b_idx_q <= idx_d;
        b_sat_q <= sat_d;
      end
    end
  end

  assign out_valid = b_valid_q & ~flush;
  assign out_idx   = b_idx_q;
  assign out_sat   = b_sat_q;

endmodule

// File: rtl/scd_cal_table.sv
module scd_cal_table #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic [CODE_W-1:0] raddr,
  output logic [CODE_W-1:0] rdata
);
  localparam int DEPTH = 1 << CODE_W;

  logic [CODE_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= CODE_W'(i);
      else if (we && (waddr == CODE_W'(i)))
        mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/scd_delay_prog.sv
module scd_delay_prog #(
  parameter int CORR_W      = 16,
  parameter int SCALE_W     = 16,
  parameter int FRAC_W      = 15,
  parameter int CODE_W      = 8,
  parameter int PS_PER_STEP = 1000,
  parameter int GUARD_CYC   = 16,
  parameter int LATE_CYC    = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pps_in,
  input  logic                     corr_valid,
  input  logic signed [CORR_W-1:0] corr_ps,
  input  logic [SCALE_W-1:0]       gain_q15,
  input  logic [CODE_W-1:0]        code_offset,
  input  logic                     cal_we,
  input  logic [CODE_W-1:0]        cal_addr,
  input  logic [CODE_W-1:0]        cal_wdata,
  output logic [CODE_W-1:0]        delay_code,
  output logic                     load_strobe,
  output logic                     sat_flag,
  output logic                     stale_flag
);
  import scd_pkg::*;

  logic              pps_rise;
  scd_phase_e        phase;
  logic              sc_valid, sc_sat;
  logic [CODE_W-1:0] sc_idx, tbl_rd;

  scd_edge_timer #(
    .GUARD_CYC (GUARD_CYC),
    .LATE_CYC  (LATE_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pps_in   (pps_in),
    .pps_rise (pps_rise),
    .phase    (phase)
  );

  scd_scaler #(
    .CORR_W      (CORR_W),
    .SCALE_W     (SCALE_W),
    .FRAC_W      (FRAC_W),
    .CODE_W      (CODE_W),
    .PS_PER_STEP (PS_PER_STEP)
  ) u_scaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (pps_rise),
    .in_valid  (corr_valid),
    .corr      (corr_ps),
    .scale     (gain_q15),
    .offset    (code_offset),
    .out_valid (sc_valid),
    .out_idx   (sc_idx),
    .out_sat   (sc_sat)
  );

  scd_cal_table #(
    .CODE_W (CODE_W)
  ) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cal_we),
    .waddr (cal_addr),
    .wdata (cal_wdata),
    .raddr (sc_idx),
    .rdata (tbl_rd)
  );

  // pending report, output registers and period bookkeeping
  logic              pend_q, pend_d;
  logic [CODE_W-1:0] pcode_q, pcode_d;
  logic              psat_q, psat_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              sat_q, sat_d;
  logic              stb_q, stb_d;
  logic              stale_q, stale_d;
  logic              done_q, done_d;   // a load occurred in this period
  logic              seen_q, seen_d;   // at least one PPS rise observed
  logic              load_go;

  always_comb begin
    pend_d  = pend_q;
    pcode_d = pcode_q;
    psat_d  = psat_q;
    code_d  = code_q;
    sat_d   = sat_q;
    stb_d   = 1'b0;
    stale_d = stale_q;
    done_d  = done_q;
    seen_d  = seen_q;
    load_go = pend_q && (phase == PH_OPEN) && !pps_rise;

    if (load_go) begin
      code_d  = pcode_q;
      sat_d   = psat_q;
      stb_d   = 1'b1;
      stale_d = 1'b0;
      done_d  = 1'b1;
      pend_d  = 1'b0;
    end
    if (sc_valid) begin
      pend_d  = 1'b1;
      pcode_d = tbl_rd;
      psat_d  = sc_sat;
    end
    if (pps_rise) begin
      pend_d = 1'b0;
      done_d = 1'b0;
      seen_d = 1'b1;
      if (seen_q && !done_q)
        stale_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pcode_q <= '0;
      psat_q  <= 1'b0;
      code_q  <= '0;
      sat_q   <= 1'b0;
      stb_q   <= 1'b0;
      stale_q <= 1'b0;
      done_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pcode_q <= pcode_d;
      psat_q  <= psat_d;
      code_q  <= code_d;
      sat_q   <= sat_d;
      stb_q   <= stb_d;
      stale_q <= stale_d;
      done_q  <= done_d;
      seen_q  <= seen_d;
    end
  end

  assign delay_code  = code_q;
  assign load_strobe = stb_q;
  assign sat_flag    = sat_q;
  assign stale_flag  = stale_q;

endmodule

// File: rtl/scd_delay_prog_chk.sv
module scd_delay_prog_chk #(
  parameter int GUARD_CYC = 16,
  parameter int LATE_CYC  = 1000,
  parameter int CODE_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pps_in,
  input logic [CODE_W-1:0] delay_code,
  input logic              load_strobe,
  input logic              sat_flag,
  input logic              stale_flag
);
  localparam int SMAX = LATE_CYC + 2;
  localparam int SW   = $clog2(SMAX + 1);

  logic          pps_q;
  logic [SW-1:0] since_q;

  // independent count of edges since the sampled PPS rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pps_q   <= 1'b0;
      since_q <= '0;
    end else begin
      pps_q <= pps_in;
      if (pps_in && !pps_q)
        since_q <= '0;
      else if (since_q != SW'(SMAX))
        since_q <= since_q + 1'b1;
    end
  end

  p_load_window_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> (int'(since_q) >= GUARD_CYC + 1 && int'(since_q) <= LATE_CYC + 1));

  p_code_moves_with_strobe_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(delay_code) |-> load_strobe);

  p_sat_moves_with_strobe_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sat_flag) |-> load_strobe);

  p_stale_rises_at_edge_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_flag) |-> (since_q == '0));

  p_stale_cleared_by_load_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> !stale_flag);

endmodule

bind scd_delay_prog scd_delay_prog_chk #(
  .GUARD_CYC (GUARD_CYC),
  .LATE_CYC  (LATE_CYC),
  .CODE_W    (CODE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pps_in      (pps_in),
  .delay_code  (delay_code),
  .load_strobe (load_strobe),
  .sat_flag    (sat_flag),
  .stale_flag  (stale_flag)
);

// File: tb/scd_delay_prog_tb.sv
module scd_delay_prog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 8;
  localparam int LATE       = 60;
  localparam int PER        = 100;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               pps_in = 1'b0;
  logic               corr_valid = 1'b0;
  logic signed [15:0] corr_ps = '0;
  logic [15:0]        gain_q15 = 16'd32768;
  logic [7:0]         code_offset = 8'd128;
  logic               cal_we = 1'b0;
  logic [7:0]         cal_addr = '0;
  logic [7:0]         cal_wdata = '0;
  logic [7:0]         delay_code;
  logic               load_strobe, sat_flag, stale_flag;

  int n_checks = 0;
  int n_bad    = 0;
  int load_cnt = 0;
  int tb_since = 0;
  logic pps_prev = 1'b0;
  bit exp_stale = 1'b0;
  int exp_code = 0;
  bit exp_sat  = 1'b0;
  int tbl_m [256];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scd_delay_prog #(
    .GUARD_CYC (GUARD),
    .LATE_CYC  (LATE)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pps_in      (pps_in),
    .corr_valid  (corr_valid),
    .corr_ps     (corr_ps),
    .gain_q15    (gain_q15),
    .code_offset (code_offset),
    .cal_we      (cal_we),
    .cal_addr    (cal_addr),
    .cal_wdata   (cal_wdata),
    .delay_code  (delay_code),
    .load_strobe (load_strobe),
    .sat_flag    (sat_flag),
    .stale_flag  (stale_flag)
  );

  function automatic void check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // step index from R2, clamp from R3
  function automatic void model(input int c, input int g, input int off, output int idx, output bit sat);
    longint p, s, b, q, t;
    p = longint'(c) * longint'(g);
    s = p >>> 15;
    b = (s >= 0) ? s + 500 : s - 500;
    q = b / 1000;
    t = q + longint'(off);
    if (t < 0) begin idx = 0; sat = 1'b1; end
    else if (t > 255) begin idx = 255; sat = 1'b1; end
    else begin idx = int'(t); sat = 1'b0; end
  endfunction

  // bench-side edge counter for the R5 window
  always @(posedge clk) begin
    pps_prev <= pps_in;
    if (pps_in && !pps_prev) tb_since <= 0;
    else if (tb_since < 100000) tb_since <= tb_since + 1;
  end

  always @(negedge clk) begin
    if (rst_n && load_strobe) begin
      load_cnt++;
      check(tb_since >= GUARD + 1 && tb_since <= LATE + 1, "R5 load window", tb_since, GUARD + 1);
    end
  end

  task automatic cal_write(input int a, input int d);
    @(negedge clk);
    cal_we = 1'b1; cal_addr = 8'(a); cal_wdata = 8'(d);
    @(negedge clk);
    cal_we = 1'b0;
    tbl_m[a] = d;
  endtask

  task automatic run_period(input bit send, input int dly, input int c, input int g,
                            input int off, input string req);
    int n0, idx;
    bit s, will_load;
    gain_q15 = 16'(g);
    code_offset = 8'(off);
    @(negedge clk) pps_in = 1'b1;
    @(negedge clk) pps_in = 1'b0;
    check(stale_flag == exp_stale, "R8 stale at edge", stale_flag, exp_stale);
    n0 = load_cnt;
    repeat (dly) @(negedge clk);
    if (send) begin
      corr_valid = 1'b1; corr_ps = 16'(c);
      @(negedge clk);
      corr_valid = 1'b0;
    end
    repeat (PER - 2 - dly - (send ? 1 : 0)) @(negedge clk);
    will_load = send && (dly <= LATE - 8);
    if (will_load) begin
      model(c, g, off, idx, s);
      exp_code = tbl_m[idx];
      exp_sat  = s;
    end
    check(int'(delay_code) == exp_code, {req, " code"}, delay_code, exp_code);
    check(sat_flag == exp_sat, {req, " R3 sat"}, sat_flag, exp_sat);
    check(load_cnt - n0 == (will_load ? 1 : 0), {req, " R9 strobe count"}, load_cnt - n0, will_load ? 1 : 0);
    exp_stale = !will_load;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240512);
    for (int i = 0; i < 256; i++) tbl_m[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(delay_code == 8'd0, "R1 code", delay_code, 0);
    check(load_strobe == 1'b0, "R1 strobe", load_strobe, 0);
    check(sat_flag == 1'b0, "R1 sat", sat_flag, 0);
    check(stale_flag == 1'b0, "R1 stale", stale_flag, 0);

    // R4 remapped entry
    cal_write(130, 77);
    run_period(1, 10, 2000, 32768, 128, "R4 table");
    // R2 rounding
    run_period(1, 12, 1500, 32768, 100, "R2 round up");
    run_period(1, 12, -1500, 32768, 100, "R2 round neg");
    run_period(1, 12, 1499, 32768, 100, "R2 round down");
    // R3 clamps and exact top
    run_period(1, 20, 32767, 36044, 240, "R3 clamp high");
    run_period(1, 20, -32768, 36044, 10, "R3 clamp low");
    run_period(1, 20, 15000, 32768, 240, "R3 exact top");
    // R6 early report waits for the window
    run_period(1, 0, 5000, 32768, 50, "R6 early");
    // R8 empty period, then stale seen at next edge
    run_period(0, 0, 0, 32768, 50, "R8 empty");
    // R7 late report dropped
    run_period(1, LATE + 3, 9000, 32768, 50, "R7 late");
    run_period(0, 0, 0, 32768, 50, "R7 after drop");
    run_period(1, 30, -7000, 30000, 90, "R8 recover");

    for (int k = 0; k < 40; k++) begin
      bit snd, late;
      int d, c, g, off;
      if ($urandom % 4 == 0) cal_write(int'($urandom % 256), int'($urandom % 256));
      snd  = ($urandom % 5) != 0;
      late = ($urandom % 8) == 0;
      d    = late ? (LATE + 3 + int'($urandom % 20)) : int'($urandom % (LATE - 7));
      c    = int'($urandom % 60001) - 30000;
      g    = 29491 + int'($urandom % 6554);
      off  = int'($urandom % 256);
      run_period(snd, d, c, g, off, "R2 R4 random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule